// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a successive-approximation analog-to-digital converter. A start request comes in on the host bus. The block then finds the input level with a binary search that sets one trial bit per clock, from the most significant bit down to the least. On every clock it drives the current trial code to an external DAC. In the same cycle it reads back a single comparator bit that says whether the DAC level lies above the analog input.

A host uses active-low chip-select, write and read strobes:

- A write, taken while chip select is low, starts a conversion.
- An interrupt line stays high while the search runs.
- An end-of-conversion flag rises when the finished code has been copied into the output register.
- The data bus is driven with that register only while chip select and read are both low. At all other times it floats.

The strobes are taken as synchronous to the block clock.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, `intr`, `eoc` and `bus_oe` are low and `dac_code` is all zeros.
- R2: A start request is the first clock edge at which `cs_n` and `wr_n` are both sampled low. After that edge, `dac_code` holds only its most significant bit set.
- R3: At each search step the bit under trial is cleared when `cmp_above` is 1 and kept when it is 0, and the next lower bit is set. The final code is the largest code whose DAC level is not above the input. With `cmp_above = (dac_code > vin)` the final code therefore equals `vin`.
- R4: `intr` goes high at the start edge and stays high for exactly DATA_W clock cycles. `eoc` rises at the same edge at which `intr` falls. The two are never high together.
- R5: When the search finishes, the final code is copied into the output register. The register keeps that value until the next conversion finishes.
- R6: `bus_oe` is high, and `bus_data` carries the output register, only while `cs_n` and `rd_n` are both low. Otherwise `bus_oe` is low and `bus_data` is high-impedance.
- R7: A write strobe that is held low for many cycles starts exactly one conversion.
- R8: A new start request during a conversion abandons it and restarts the search from an all-zero register with the MSB under trial. The restarted search lasts a full DATA_W cycles. The output register keeps its previous value until the new search finishes.
- R9: `eoc` clears at the start edge of the next conversion.
- R10: A write strobe while `cs_n` is high does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one search step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Start strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_above | input | 1 | Comparator: 1 when the DAC level is above the input |
| dac_code | output | DATA_W | Trial code driven to the DAC |
| intr | output | 1 | High while a conversion runs |
| eoc | output | 1 | End of conversion, result ready |
| bus_oe | output | 1 | High while the data bus is driven |
| bus_data | output | DATA_W | Tri-stated result bus |

## Verification
The bench targets the following corner cases, one scenario each:
- **All-zeros and all-ones inputs.** A design with an inverted comparator sense, or with the trial-bit update placed off by one, returns a wrong code here.
- **Exact intermediate trial codes.** Checking these catches a search that walks the bits in the wrong order.
- **Write strobe held low.** A design that starts on the level rather than on the edge keeps `intr` high forever.
- **Abort.** A restart that fails to clear the register gives a mixed code. A design that releases the output register early exposes a partial result on the bus.
- **Write with chip select high.** A write that ignores chip select would start a conversion.
- **Read strobe alone.** A read that ignores chip select would drive the bus.
- **End-of-conversion timing.** A design that latches the result one cycle late raises `eoc` a cycle after `intr` falls.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } sar_phase_e;

    function automatic int unsigned idx_width(input int unsigned w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/sar_strobe.sv
module sar_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic start
);

    typedef struct packed {
        logic wr_seen;
    } strobe_st_t;

    strobe_st_t st_d, st_q;
    logic       wr_act;

    always_comb begin
        wr_act     = !cs_n && !wr_n;
        st_d       = st_q;
        st_d.wr_seen = wr_act;
        start      = wr_act && !st_q.wr_seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R7

endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_above,
    output logic [DATA_W-1:0] trial_code,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] final_code
);

    localparam int unsigned IDX_W = idx_width(DATA_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        sar_phase_e        phase;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] trial;
    } search_st_t;

    search_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        finish     = 1'b0;
        final_code = st_q.trial;
        if (start) begin
            st_d.phase = PH_BUSY;
            st_d.idx   = TOP_IDX;
            st_d.trial = MSB_ONE;
        end else if (st_q.phase == PH_BUSY) begin
            st_d.trial[st_q.idx] = !cmp_above;
            if (st_q.idx == '0) begin
                st_d.phase = PH_IDLE;
                finish     = 1'b1;
                final_code = st_d.trial;
            end else begin
                st_d.idx                 = st_q.idx - IDX_W'(1);
                st_d.trial[st_q.idx - IDX_W'(1)] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.idx   <= '0;
            st_q.trial <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trial_code = st_q.trial;
    assign busy       = (st_q.phase == PH_BUSY);

    AST_START_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (trial_code == MSB_ONE) && busy); // R2
    AST_ABOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && cmp_above) |=> (trial_code < $past(trial_code))); // R3
    AST_BELOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && !cmp_above && st_q.idx != '0) |=> (trial_code > $past(trial_code))); // R3
    AST_FINISH_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy); // R4

endmodule

// File: rtl/sar_bus_port.sv
module sar_bus_port #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              finish,
    input  logic [DATA_W-1:0] final_code,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              eoc,
    output logic              oe,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic              eoc;
        logic [DATA_W-1:0] result;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.eoc = 1'b0;
        end else if (finish) begin
            st_d.eoc    = 1'b1;
            st_d.result = final_code;
        end
        oe = !cs_n && !rd_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eoc    = st_q.eoc;
    assign result = st_q.result;

    AST_EOC_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> eoc && (result == $past(final_code))); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(result)); // R5
    AST_EOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !eoc); // R9

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cmp_above,
    output logic [DATA_W-1:0] dac_code,
    output logic              intr,
    output logic              eoc,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_data
);

    logic              start;
    logic              finish;
    logic [DATA_W-1:0] final_code;
    logic [DATA_W-1:0] result;

    sar_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .wr_n  (wr_n),
        .start (start)
    );

    sar_search #(.DATA_W(DATA_W)) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmp_above  (cmp_above),
        .trial_code (dac_code),
        .busy       (intr),
        .finish     (finish),
        .final_code (final_code)
    );

    sar_bus_port #(.DATA_W(DATA_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .finish     (finish),
        .final_code (final_code),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .eoc        (eoc),
        .oe         (bus_oe),
        .result     (result)
    );

    assign bus_data = bus_oe ? result : {DATA_W{1'bz}};

    AST_NO_OE_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe); // R6
    AST_INTR_EOC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(intr && eoc)); // R4

endmodule

// File: tb/sar_bus_ctrl_tb.sv
module sar_bus_ctrl_tb;

    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic [N-1:0] vin = '0;
    logic         cmp_above;
    logic [N-1:0] dac_code;
    logic         intr;
    logic         eoc;
    logic         bus_oe;
    logic [N-1:0] bus_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    assign cmp_above = (dac_code > vin);

    sar_bus_ctrl #(.DATA_W(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .cmp_above (cmp_above),
        .dac_code  (dac_code),
        .intr      (intr),
        .eoc       (eoc),
        .bus_oe    (bus_oe),
        .bus_data  (bus_data)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_write();
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic read_bus(input logic [N-1:0] exp, input string req);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        #1;
        check(bus_oe === 1'b1, req, int'(bus_oe), 1);
        check(bus_data === exp, req, int'(bus_data), int'(exp));
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // full conversion of v; checks intr window, eoc timing and the result (R3 R4 R5)
    task automatic t_convert(input logic [N-1:0] v);
        vin = v;
        pulse_write();
        check(intr === 1'b1 && eoc === 1'b0, "R9", int'({intr, eoc}), 2);
        check(dac_code === 8'h80, "R2", int'(dac_code), 8'h80);
        repeat (N-1) @(negedge clk);
        check(intr === 1'b1, "R4", int'(intr), 1);
        @(negedge clk);
        check(intr === 1'b0 && eoc === 1'b1, "R4", int'({intr, eoc}), 1);
        read_bus(v, "R3");
    endtask

    task automatic t_reset();
        check(intr === 1'b0 && eoc === 1'b0 && bus_oe === 1'b0, "R1",
              int'({intr, eoc, bus_oe}), 0);
        check(dac_code === '0, "R1", int'(dac_code), 0);
    endtask

    // trial sequence for input 0xA5: 80, C0, A0 (R2 R3)
    task automatic t_trace();
        vin = 8'hA5;
        pulse_write();
        check(dac_code === 8'h80, "R2", int'(dac_code), 8'h80);
        @(negedge clk);
        check(dac_code === 8'hC0, "R3", int'(dac_code), 8'hC0);
        @(negedge clk);
        check(dac_code === 8'hA0, "R3", int'(dac_code), 8'hA0);
        repeat (N) @(negedge clk);
        read_bus(8'hA5, "R3");
    endtask

    task automatic t_held_write();
        vin = 8'h3C;
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
        repeat (3*N) @(negedge clk);
        check(intr === 1'b0 && eoc === 1'b1, "R7", int'({intr, eoc}), 1);
        cs_n = 1'b1; wr_n = 1'b1;
        read_bus(8'h3C, "R7");
    endtask

    task automatic t_abort();
        vin = 8'h33;
        pulse_write();
        repeat (2) @(negedge clk);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        #1;
        check(bus_data === 8'h3C, "R8", int'(bus_data), 8'h3C);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        vin = 8'hC4;
        pulse_write();
        check(dac_code === 8'h80 && intr === 1'b1, "R8", int'(dac_code), 8'h80);
        repeat (N-1) @(negedge clk);
        check(intr === 1'b1, "R8", int'(intr), 1);
        @(negedge clk);
        check(eoc === 1'b1, "R8", int'(eoc), 1);
        read_bus(8'hC4, "R8");
    endtask

    task automatic t_no_cs_write();
        vin = 8'h11;
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        check(intr === 1'b0 && eoc === 1'b1, "R10", int'({intr, eoc}), 1);
        read_bus(8'hC4, "R10");
    endtask

    task automatic t_read_gate();
        @(negedge clk); rd_n = 1'b0;
        #1;
        check(bus_oe === 1'b0, "R6", int'(bus_oe), 0);
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b0;
        #1;
        check(bus_oe === 1'b0, "R6", int'(bus_oe), 0);
        @(negedge clk); cs_n = 1'b1;
        read_bus(8'hC4, "R6");
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_convert(8'h00);
        t_convert(8'hFF);
        t_convert(8'h5A);
        t_convert(8'h80);
        t_trace();
        t_held_write();
        t_abort();
        t_no_cs_write();
        t_read_gate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule